// File: doc/BRIEF.md
# Serial Flash Status Register Controller

This block is the slave-side logic of a serial-flash-style SPI device that owns the status register. It watches chip select, serial clock and serial data in, with the serial clock running in SPI mode 0. It decodes three commands: a latch-enable command, a status read and a status write. A status write is committed only when chip select rises exactly after the eighth data bit. A committed write then runs a self-timed busy cycle, and the new register image takes effect when that cycle ends.

All serial inputs and the write-protect pin pass through two-flop synchronizers into the system clock domain. The system clock must run several times faster than the serial clock. Status data is driven out on falling serial clock edges. A separate output-enable tells the pad when the data output should leave high impedance. The four block-protect bits are exported for the memory array. A hardware protection mode blocks status writes. It is in force when the register's write-disable bit is set and the write-protect pin is held low.

Top module: `spi_status_top`

## Requirements
- R1: After reset the status byte reads 0x00, `protBits` is 0 and `sdoEn` is low.
- R2: Command 0x06 (latch enable), when the write cycle is not running, sets status bit 1 (the enable latch).
- R3: Command 0x05 returns the status byte MSB first on `sdo`, one bit per falling `sclk` edge. The read repeats the byte for as long as `csN` stays low. `sdoEn` is high only during that read. The status layout is: bit 7 write-disable, bit 6 always 0, bits 5..2 protect bits 3..0, bit 1 enable latch, bit 0 write-in-progress.
- R4: Command 0x01 followed by one data byte, with `csN` rising right after the 16th bit and the enable latch set, loads data bit 7 into the write-disable bit and data bits 5..2 into the protect bits. Data bits 6, 1 and 0 have no effect.
- R5: A status write issued while the enable latch is clear changes nothing.
- R6: A status write whose `csN` rises after 15 or 17 bits instead of 16 is discarded, and the enable latch stays set.
- R7: A committed write keeps write-in-progress at 1 for `WRITE_CYCLES` system clocks. The new fields appear only when it ends.
- R8: When the write cycle completes, the enable latch clears.
- R9: While the write-disable bit is 1 and `wpN` is low, status writes are ignored. With `wpN` high the same write is accepted.
- R10: While the write cycle runs, a status read still works and any other command, including a status write, is ignored.
- R11: `protBits` always equals status bits 5..2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| csN | input | 1 | Chip select, active low |
| sclk | input | 1 | Serial clock, mode 0 |
| mosi | input | 1 | Serial data in, sampled on rising `sclk` |
| wpN | input | 1 | Write-protect pin, active low |
| sdo | output | 1 | Serial data out, changes after falling `sclk` |
| sdoEn | output | 1 | High while `sdo` must be driven, low for high impedance |
| protBits | output | 4 | Block-protect bits for the memory array |

## Verification
The commit decision at chip-select rise coincides with two other inputs to that decision: the protection-pin level and the enable latch. The bench toggles `wpN` and the latch-enable command at random before each write and also truncates or extends the frame by one bit. A bench model predicts whether the image changes. The second overlap is a command that arrives while the self-timed cycle runs. A read issued immediately after a commit must show write-in-progress and the old fields in both streamed bytes. A status write sent inside the busy window must leave no trace once the first write completes.

// File: rtl/spi_status_pkg.sv
package spi_status_pkg;

  localparam int BYTE_BITS = 8;
  localparam int CNT_W     = $clog2(BYTE_BITS);

  localparam logic [7:0] OP_LATCH_EN = 8'h06;
  localparam logic [7:0] OP_READ_ST  = 8'h05;
  localparam logic [7:0] OP_WRITE_ST = 8'h01;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CMD,
    ST_DATA,
    ST_TAIL,
    ST_READ,
    ST_SKIP
  } ctrlState_t;

  typedef struct packed {
    logic shiftIn;
    logic captureData;
    logic setWel;
    logic commit;
    logic emitBit;
    logic emitFirst;
  } ctrlStrobe_t;

endpackage

// File: rtl/spi_status_sync.sv
module spi_status_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic csNIn,
  input  logic sclkIn,
  input  logic mosiIn,
  input  logic wpNIn,
  output logic csN,
  output logic mosi,
  output logic wpN,
  output logic sclkRise,
  output logic sclkFall,
  output logic csRise,
  output logic csFall
);

  localparam logic [3:0] RST_VAL = 4'b1001;

  logic [3:0] stage [STAGES];
  logic       sclkPrev;
  logic       csPrev;
  logic       sclkNow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stage[0] <= RST_VAL;
    else       stage[0] <= {csNIn, sclkIn, mosiIn, wpNIn};
  end

  for (genvar g = 1; g < STAGES; g++) begin : gStage
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) stage[g] <= RST_VAL;
      else       stage[g] <= stage[g-1];
    end
  end

  assign csN     = stage[STAGES-1][3];
  assign sclkNow = stage[STAGES-1][2];
  assign mosi    = stage[STAGES-1][1];
  assign wpN     = stage[STAGES-1][0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkPrev <= 1'b0;
      csPrev   <= 1'b1;
    end else begin
      sclkPrev <= sclkNow;
      csPrev   <= csN;
    end
  end

  assign sclkRise = sclkNow & ~sclkPrev;
  assign sclkFall = ~sclkNow & sclkPrev;
  assign csRise   = csN & ~csPrev;
  assign csFall   = ~csN & csPrev;

endmodule

// File: rtl/spi_status_ctrl.sv
module spi_status_ctrl
  import spi_status_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        csN,
  input  logic        wpN,
  input  logic        sclkRise,
  input  logic        sclkFall,
  input  logic        csRise,
  input  logic        csFall,
  input  logic [7:0]  rxNext,
  input  logic        busy,
  input  logic        wel,
  input  logic        srwd,
  output ctrlStrobe_t strb,
  output logic        sdoEn
);

  ctrlState_t       state, nxtState;
  logic [CNT_W-1:0] bitCnt, nxtCnt;
  logic             hpm;
  logic             byteDone;

  assign hpm      = srwd & ~wpN;
  assign byteDone = (bitCnt == CNT_W'(BYTE_BITS - 1));
  assign sdoEn    = (state == ST_READ);

  always_comb begin
    strb     = '0;
    nxtState = state;
    nxtCnt   = bitCnt;
    if (csRise) begin
      nxtState = ST_IDLE;
      if (state == ST_TAIL && wel && !hpm && !busy) strb.commit = 1'b1;
    end else if (csFall) begin
      nxtState = ST_CMD;
      nxtCnt   = '0;
    end else begin
      unique case (state)
        ST_CMD: if (sclkRise) begin
          strb.shiftIn = 1'b1;
          nxtCnt       = bitCnt + 1'b1;
          if (byteDone) begin
            if (rxNext == OP_LATCH_EN && !busy) begin
              strb.setWel = 1'b1;
              nxtState    = ST_SKIP;
            end else if (rxNext == OP_READ_ST) begin
              nxtState = ST_READ;
            end else if (rxNext == OP_WRITE_ST && !busy) begin
              nxtState = ST_DATA;
            end else begin
              nxtState = ST_SKIP;
            end
          end
        end
        ST_DATA: if (sclkRise) begin
          strb.shiftIn = 1'b1;
          nxtCnt       = bitCnt + 1'b1;
          if (byteDone) begin
            strb.captureData = 1'b1;
            nxtState         = ST_TAIL;
          end
        end
        ST_TAIL: if (sclkRise) nxtState = ST_SKIP;
        ST_READ: if (sclkFall) begin
          strb.emitBit   = 1'b1;
          strb.emitFirst = (bitCnt == '0);
          nxtCnt         = bitCnt + 1'b1;
        end
        ST_IDLE, ST_SKIP: ;
        default: nxtState = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      bitCnt <= '0;
    end else begin
      state  <= nxtState;
      bitCnt <= nxtCnt;
    end
  end

  // the output is driven only while the chip was selected one cycle earlier
  assert_sdo_selected_R3: assert property (@(posedge clk) disable iff (!rstN)
    sdoEn |-> !$past(csN));

  // a data capture always follows a write command in the same frame
  assert_capture_after_cmd_R4: assert property (@(posedge clk) disable iff (!rstN)
    strb.captureData |-> (state == ST_DATA) && !csN);

endmodule

// File: rtl/spi_status_dp.sv
module spi_status_dp
  import spi_status_pkg::*;
#(
  parameter int WRITE_CYCLES = 64
) (
  input  logic        clk,
  input  logic        rstN,
  input  ctrlStrobe_t strb,
  input  logic        mosi,
  input  logic        wpN,
  output logic [7:0]  rxNext,
  output logic        wel,
  output logic        busy,
  output logic        srwd,
  output logic [3:0]  bp,
  output logic        sdo
);

  localparam int TIMER_W = $clog2(WRITE_CYCLES + 1);

  logic [6:0]         rxShift;
  logic [4:0]         dataHold;
  logic [TIMER_W-1:0] timer;
  logic               cycleDone;
  logic [7:0]         status;
  logic [6:0]         txShift;

  assign rxNext    = {rxShift, mosi};
  assign cycleDone = busy && (timer == TIMER_W'(1));
  assign status    = {srwd, 1'b0, bp, wel, busy};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift  <= '0;
      dataHold <= '0;
    end else begin
      if (strb.shiftIn)     rxShift  <= rxNext[6:0];
      if (strb.captureData) dataHold <= {rxNext[7], rxNext[5:2]};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy  <= 1'b0;
      timer <= '0;
      wel   <= 1'b0;
      srwd  <= 1'b0;
      bp    <= '0;
    end else begin
      if (strb.commit) begin
        busy  <= 1'b1;
        timer <= TIMER_W'(WRITE_CYCLES);
      end else if (cycleDone) begin
        busy  <= 1'b0;
        timer <= '0;
        srwd  <= dataHold[4];
        bp    <= dataHold[3:0];
      end else if (busy) begin
        timer <= timer - 1'b1;
      end
      if (cycleDone)        wel <= 1'b0;
      else if (strb.setWel) wel <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sdo     <= 1'b0;
      txShift <= '0;
    end else if (strb.emitBit) begin
      if (strb.emitFirst) begin
        sdo     <= status[7];
        txShift <= status[6:0];
      end else begin
        sdo     <= txShift[6];
        txShift <= {txShift[5:0], 1'b0};
      end
    end
  end

  // register fields only move on the cycle the busy window closes
  assert_fields_at_end_R7: assert property (@(posedge clk) disable iff (!rstN)
    ({srwd, bp} != $past({srwd, bp})) |-> ($past(busy) && !busy));

  // the enable latch is gone once the cycle finishes
  assert_wel_cleared_R8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> !wel);

  // a cycle only starts with the latch set beforehand
  assert_start_needs_wel_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(wel));

  // no cycle starts under hardware protection
  assert_no_start_protected_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> !($past(srwd) && !$past(wpN)));

  // the latch cannot move while the cycle is running
  assert_wel_frozen_busy_R10: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> $stable(wel));

endmodule

// File: rtl/spi_status_top.sv
module spi_status_top
  import spi_status_pkg::*;
#(
  parameter int WRITE_CYCLES = 64,
  parameter int SYNC_STAGES  = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       csN,
  input  logic       sclk,
  input  logic       mosi,
  input  logic       wpN,
  output logic       sdo,
  output logic       sdoEn,
  output logic [3:0] protBits
);

  logic        csNS, mosiS, wpNS;
  logic        sclkRise, sclkFall, csRise, csFall;
  logic [7:0]  rxNext;
  logic        wel, busy, srwd;
  logic [3:0]  bp;
  ctrlStrobe_t strb;

  spi_status_sync #(.STAGES(SYNC_STAGES)) uSync (
    .clk(clk), .rstN(rstN),
    .csNIn(csN), .sclkIn(sclk), .mosiIn(mosi), .wpNIn(wpN),
    .csN(csNS), .mosi(mosiS), .wpN(wpNS),
    .sclkRise(sclkRise), .sclkFall(sclkFall),
    .csRise(csRise), .csFall(csFall)
  );

  spi_status_ctrl uCtrl (
    .clk(clk), .rstN(rstN),
    .csN(csNS), .wpN(wpNS),
    .sclkRise(sclkRise), .sclkFall(sclkFall),
    .csRise(csRise), .csFall(csFall),
    .rxNext(rxNext), .busy(busy), .wel(wel), .srwd(srwd),
    .strb(strb), .sdoEn(sdoEn)
  );

  spi_status_dp #(.WRITE_CYCLES(WRITE_CYCLES)) uDp (
    .clk(clk), .rstN(rstN),
    .strb(strb), .mosi(mosiS), .wpN(wpNS),
    .rxNext(rxNext), .wel(wel), .busy(busy), .srwd(srwd), .bp(bp), .sdo(sdo)
  );

  assign protBits = bp;

endmodule

// File: tb/tb_spi_status_top.sv
module tb_spi_status_top;

  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 8;
  localparam int WC         = 400;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic csN = 1'b1;
  logic sclk = 1'b0;
  logic mosi = 1'b0;
  logic wpN = 1'b1;
  logic sdo, sdoEn;
  logic [3:0] protBits;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;
  int unsigned cyc = 0;
  int unsigned tRise = 0;

  logic       mSrwd = 1'b0;
  logic [3:0] mBp = '0;
  logic       mWel = 1'b0;

  spi_status_top #(.WRITE_CYCLES(WC)) dut (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .mosi(mosi), .wpN(wpN),
    .sdo(sdo), .sdoEn(sdoEn), .protBits(protBits)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [7:0] expStatus();
    return {mSrwd, 1'b0, mBp, mWel, 1'b0};
  endfunction

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic shiftBits(input logic [16:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      mosi = v[i];
      waitClk(HALF);
      sclk = 1'b1;
      waitClk(HALF);
      sclk = 1'b0;
    end
  endtask

  task automatic selectChip();
    csN = 1'b0;
    waitClk(HALF);
  endtask

  task automatic deselectChip();
    waitClk(HALF);
    csN = 1'b0;
    csN = 1'b1;
    tRise = cyc;
    waitClk(2 * HALF);
  endtask

  task automatic readStatus(output logic [7:0] b0, output logic [7:0] b1);
    logic [15:0] acc;
    acc = '0;
    selectChip();
    shiftBits(17'h05, 8);
    for (int i = 0; i < 16; i++) begin
      waitClk(HALF);
      if (i == 0) chk({7'b0, sdoEn}, 8'h01, "R3 sdoEn during read");
      acc = {acc[14:0], sdo};
      sclk = 1'b1;
      waitClk(HALF);
      sclk = 1'b0;
    end
    deselectChip();
    chk({7'b0, sdoEn}, 8'h00, "R3 sdoEn after read");
    b0 = acc[15:8];
    b1 = acc[7:0];
  endtask

  task automatic latchEnable();
    selectChip();
    shiftBits(17'h06, 8);
    deselectChip();
    mWel = 1'b1;
  endtask

  // frame of 15, 16 or 17 bits; the model follows only when a commit is due
  task automatic writeStatus(input logic [7:0] data, input int nBits, input bit waitDone);
    logic [16:0] v;
    bit commit;
    if (nBits == 17)      v = {8'h01, data, 1'b1};
    else if (nBits == 15) v = {2'b0, 8'h01, data[7:1]};
    else                  v = {1'b0, 8'h01, data};
    commit = (nBits == 16) && mWel && !(mSrwd && !wpN);
    selectChip();
    shiftBits(v, nBits);
    deselectChip();
    if (commit) begin
      mSrwd = data[7];
      mBp   = data[5:2];
      mWel  = 1'b0;
    end
    if (waitDone) waitClk(WC + 50);
  endtask

  task automatic rawWrite(input logic [7:0] data);
    selectChip();
    shiftBits({1'b0, 8'h01, data}, 16);
    deselectChip();
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      summary();
      $finish;
    end
  end

  initial begin
    logic [7:0] s0, s1;
    logic [7:0] rdata;
    int pick, nBits;
    void'($urandom(32'd2024));
    waitClk(5);
    rstN = 1'b1;
    waitClk(5);

    // R1 reset state
    chk({7'b0, sdoEn}, 8'h00, "R1 sdoEn");
    chk({4'b0, protBits}, 8'h00, "R1 protBits");
    readStatus(s0, s1);
    chk(s0, 8'h00, "R1 status");
    chk(s1, 8'h00, "R3 repeated byte");

    // R5 write without latch
    writeStatus(8'h3C, 16, 1'b1);
    readStatus(s0, s1);
    chk(s0, 8'h00, "R5 no latch");

    // R2 latch enable
    latchEnable();
    readStatus(s0, s1);
    chk(s0, 8'h02, "R2 latch set");

    // R4 R7 R8 R11 full write and its timing
    writeStatus(8'hFF, 16, 1'b0);
    while (cyc < tRise + WC - 20) waitClk(1);
    chk({4'b0, protBits}, 8'h00, "R7 fields before end");
    while (cyc < tRise + WC + 20) waitClk(1);
    chk({4'b0, protBits}, 8'h0F, "R7 R11 fields after end");
    readStatus(s0, s1);
    chk(s0, 8'hBC, "R4 R8 image");

    // R10 R7 read while busy
    latchEnable();
    writeStatus(8'h08, 16, 1'b0);
    readStatus(s0, s1);
    chk(s0, 8'hBF, "R10 R7 busy read byte0");
    chk(s1, 8'hBF, "R10 R7 busy read byte1");
    waitClk(WC);
    readStatus(s0, s1);
    chk(s0, 8'h08, "R4 after busy");

    // R10 write during busy ignored
    latchEnable();
    writeStatus(8'h20, 16, 1'b0);
    rawWrite(8'h44);
    waitClk(WC + 50);
    readStatus(s0, s1);
    chk(s0, 8'h20, "R10 ignored write");

    // R9 hardware protection
    latchEnable();
    writeStatus(8'h80, 16, 1'b1);
    readStatus(s0, s1);
    chk(s0, 8'h80, "R9 set disable bit");
    wpN = 1'b0;
    waitClk(10);
    latchEnable();
    writeStatus(8'h3C, 16, 1'b1);
    readStatus(s0, s1);
    chk(s0, 8'h82, "R9 protected");
    wpN = 1'b1;
    waitClk(10);
    writeStatus(8'h3C, 16, 1'b1);
    readStatus(s0, s1);
    chk(s0, 8'h3C, "R9 unprotected");

    // R6 frame boundaries
    latchEnable();
    writeStatus(8'h14, 17, 1'b1);
    readStatus(s0, s1);
    chk(s0, 8'h3E, "R6 17 bits");
    writeStatus(8'h14, 15, 1'b1);
    readStatus(s0, s1);
    chk(s0, 8'h3E, "R6 15 bits");
    writeStatus(8'h14, 16, 1'b1);
    readStatus(s0, s1);
    chk(s0, 8'h14, "R6 16 bits");

    // random mix
    for (int it = 0; it < 30; it++) begin
      if (($urandom % 3) != 0) latchEnable();
      wpN = 1'($urandom % 2);
      waitClk(10);
      rdata = 8'($urandom);
      pick  = $urandom % 4;
      nBits = (pick == 0) ? 15 : (pick == 1) ? 17 : 16;
      writeStatus(rdata, nBits, 1'b1);
      readStatus(s0, s1);
      chk(s0, expStatus(), "R4 R5 R6 R9 random");
      chk({4'b0, protBits}, {4'b0, mBp}, "R11 random");
    end

    finished = 1'b1;
    summary();
    $finish;
  end

endmodule